// File: doc/BRIEF.md
# UART FIFO Control with Programmable Triggers

This block is the buffering and interrupt-decision part of one serial channel. It holds two byte queues: one that the host fills and the transmit shifter drains, and one that the receive shifter fills and the host drains. A one-byte register write port reaches two write-only registers. The FIFO control register turns on deep buffering, flushes either queue, and picks the trigger points. The interrupt enable register gates the two interrupt outputs.

The receive interrupt reports that enough characters are waiting. The transmit interrupt reports that enough free space has opened up. It fires only when the free space newly reaches the chosen amount. Simply enabling the interrupt while space is already plentiful does not fire it. An enhanced-function input decides whether the transmit trigger field and the upper half of the interrupt enable register can be changed.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset both counts are 0, both popped-data outputs are 0, `cfg_view` and `ier_view` are 0x00, and both interrupts are 0.
- R2: Each queue returns bytes in push order. An accepted pop updates that queue's pop-data output on the same clock edge. Otherwise the output holds.
- R3: A queue holds DEPTH (64) bytes when control bit 0 is 1, and 1 byte when it is 0. A push to a queue at capacity is dropped, and so is a pop from an empty queue. A push and a pop in the same cycle are each judged on the count before the edge. Control bit 0 reads back at `cfg_view[0]`.
- R4: A control write with bit 1 set empties the receive queue at that edge. `cfg_view[1]` then reads 1 for exactly two cycles and returns to 0. Receive pushes and pops in the write cycle and in those two cycles are dropped. The transmit queue is untouched.
- R5: A control write with bit 2 set does the same for the transmit queue. Its busy flag is `cfg_view[2]`, and the receive queue is untouched.
- R6: Control bits 7:6 pick the receive trigger, shown at `cfg_view[7:6]`: 00 is 8 characters, 01 is 16, 10 is 56 and 11 is 60. With control bit 0 at 0 the receive trigger is 1 character.
- R7: Control bits 5:4 pick the transmit trigger in free spaces, shown at `cfg_view[5:4]`: 00 is 8, 01 is 16, 10 is 32 and 11 is 56. With control bit 0 at 0 it is 1 space. The field changes only on a write made while `enh_en` is 1.
- R8: Control bit 3 is ignored, and `cfg_view[3]` always reads 0.
- R9: Interrupt enable bits 3:0 are written on every write to that register. Bits 7:4 are written only while `enh_en` is 1. All eight bits are shown at `ier_view`.
- R10: `rx_irq` is registered, and after each edge it equals the value before that edge of (enable bit 0 AND receive count >= receive trigger).
- R11: `tx_irq` is registered. It sets one edge after free space (capacity minus count) goes from below the transmit trigger to at or above it, provided enable bit 1 is 1. It clears when space falls below the trigger or enable bit 1 is 0. Turning enable bit 1 on while space is already at or above the trigger never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects FIFO control register, 1 selects interrupt enable register |
| reg_wr_data | input | 8 | Register write byte |
| enh_en | input | 1 | Enhanced-function enable, gates the guarded fields |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_push_data | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_pop_data | output | 8 | Last byte taken from the transmit queue |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Received byte in |
| rx_pop | input | 1 | Host reads a byte |
| rx_pop_data | output | 8 | Last byte taken from the receive queue |
| tx_count | output | 7 | Bytes held in the transmit queue |
| rx_count | output | 7 | Bytes held in the receive queue |
| cfg_view | output | 8 | {rx trigger, tx trigger, 0, tx flush busy, rx flush busy, deep enable} |
| ier_view | output | 8 | Interrupt enable register contents |
| rx_irq | output | 1 | Receive level interrupt |
| tx_irq | output | 1 | Transmit space interrupt |

## Verification
The queues are first driven in single-byte mode, where a second push is refused, and then filled past capacity in deep mode. Together these separate the two capacities and show drop-on-full. Receive levels are walked across a trigger by pops, which shows whether the comparison is at-or-above. The transmit interrupt is exercised three ways: enabled with space already available, a real crossing made by draining the queue, and a disable followed by a re-enable. Only the crossing may fire. A long phase then alternates fill-biased and drain-biased traffic with random register writes and flushes. It is compared each cycle with a queue-based model, which catches ordering, gating and flush-timing errors that the directed steps do not reach.

// File: rtl/uart_fifo_ctrl_pkg.sv
package uart_fifo_ctrl_pkg;

  typedef enum logic {
    SEL_FIFO_CTRL = 1'b0,
    SEL_IRQ_EN    = 1'b1
  } reg_sel_e;

  localparam int unsigned CTRL_DEEP_BIT  = 0;
  localparam int unsigned CTRL_RXFL_BIT  = 1;
  localparam int unsigned CTRL_TXFL_BIT  = 2;

  // receive trigger in characters waiting
  function automatic int unsigned rx_trig_chars(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  // transmit trigger in free spaces
  function automatic int unsigned tx_trig_spaces(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int unsigned DEPTH     = 64,
  parameter  int unsigned DATA_W    = 8,
  parameter  int unsigned FLUSH_CYC = 2,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FL_W      = $clog2(FLUSH_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cap,
  input  logic              flush_req,
  output logic              flush_busy,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [FL_W-1:0]  FL_LOAD  = FL_W'(FLUSH_CYC);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q;
  logic [FL_W-1:0]   fl_cnt;
  logic              wipe, push_ok, pop_ok;

  assign wipe    = flush_req || (fl_cnt != '0);
  assign push_ok = push && !wipe && (count_q < cap);
  assign pop_ok  = pop && !wipe && (count_q != '0);

  // storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (pop_ok) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // multi-cycle flush sequencer
  always_ff @(posedge clk) begin
    if (rst)              fl_cnt <= '0;
    else if (flush_req)   fl_cnt <= FL_LOAD;
    else if (fl_cnt != 0) fl_cnt <= fl_cnt - 1'b1;
  end

  assign flush_busy = (fl_cnt != '0);
  assign count      = count_q;

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import uart_fifo_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       enh_en,
  output logic       deep_en,
  output logic [1:0] rx_trig,
  output logic [1:0] tx_trig,
  output logic [7:0] ier,
  output logic       rx_flush,
  output logic       tx_flush
);

  logic ctrl_wr, ier_wr;
  logic unused_rsvd;

  assign ctrl_wr     = wr_en && (reg_sel_e'(wr_sel) == SEL_FIFO_CTRL);
  assign ier_wr      = wr_en && (reg_sel_e'(wr_sel) == SEL_IRQ_EN);
  assign unused_rsvd = wr_data[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      deep_en <= 1'b0;
      rx_trig <= 2'b00;
      tx_trig <= 2'b00;
      ier     <= 8'h00;
    end else begin
      if (ctrl_wr) begin
        deep_en <= wr_data[CTRL_DEEP_BIT];
        rx_trig <= wr_data[7:6];
        if (enh_en) tx_trig <= wr_data[5:4];
      end
      if (ier_wr) begin
        ier[3:0] <= wr_data[3:0];
        if (enh_en) ier[7:4] <= wr_data[7:4];
      end
    end
  end

  assign rx_flush = ctrl_wr && wr_data[CTRL_RXFL_BIT];
  assign tx_flush = ctrl_wr && wr_data[CTRL_TXFL_BIT];

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             deep_en,
  input  logic [CNT_W-1:0] cap,
  input  logic [1:0]       rx_trig,
  input  logic [1:0]       tx_trig,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  output logic             rx_irq,
  output logic             tx_irq
);

  int unsigned rx_thr, tx_thr;
  logic        rx_hit, tx_room, room_q;

  always_comb begin
    rx_thr  = deep_en ? rx_trig_chars(rx_trig)  : 1;
    tx_thr  = deep_en ? tx_trig_spaces(tx_trig) : 1;
    rx_hit  = 32'(rx_count) >= rx_thr;
    tx_room = (32'(tx_count) + tx_thr) <= 32'(cap);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
      room_q <= 1'b0;
    end else begin
      rx_irq <= rx_en && rx_hit;
      // hold while still roomy, set only on a fresh rise of room
      tx_irq <= tx_en && tx_room && (tx_irq || !room_q);
      room_q <= tx_room;
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_ctrl_pkg::*;
#(
  parameter  int unsigned DEPTH     = 64,
  parameter  int unsigned DATA_W    = 8,
  parameter  int unsigned FLUSH_CYC = 2,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [7:0]        reg_wr_data,
  input  logic              enh_en,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic [7:0]        cfg_view,
  output logic [7:0]        ier_view,
  output logic              rx_irq,
  output logic              tx_irq
);

  localparam logic [CNT_W-1:0] CAP_DEEP = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

  logic       deep_en, rx_flush, tx_flush, rx_busy, tx_busy;
  logic [1:0] rx_trig, tx_trig;
  logic [7:0] ier;
  logic [CNT_W-1:0] cap;

  uart_fifo_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_sel   (reg_wr_sel),
    .wr_data  (reg_wr_data),
    .enh_en   (enh_en),
    .deep_en  (deep_en),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .ier      (ier),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  assign cap = deep_en ? CAP_DEEP : CAP_ONE;

  uart_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FLUSH_CYC(FLUSH_CYC)) u_tx_fifo (
    .clk        (clk),
    .rst        (rst),
    .cap        (cap),
    .flush_req  (tx_flush),
    .flush_busy (tx_busy),
    .push       (tx_push),
    .push_data  (tx_push_data),
    .pop        (tx_pop),
    .pop_data   (tx_pop_data),
    .count      (tx_count)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FLUSH_CYC(FLUSH_CYC)) u_rx_fifo (
    .clk        (clk),
    .rst        (rst),
    .cap        (cap),
    .flush_req  (rx_flush),
    .flush_busy (rx_busy),
    .push       (rx_push),
    .push_data  (rx_push_data),
    .pop        (rx_pop),
    .pop_data   (rx_pop_data),
    .count      (rx_count)
  );

  uart_fifo_irq #(.CNT_W(CNT_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .deep_en  (deep_en),
    .cap      (cap),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .rx_en    (ier[0]),
    .tx_en    (ier[1]),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq)
  );

  assign cfg_view = {rx_trig, tx_trig, 1'b0, tx_busy, rx_busy, deep_en};
  assign ier_view = ier;

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic             reg_wr_sel,
  input logic [7:0]       reg_wr_data,
  input logic             enh_en,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic [7:0]       cfg_view,
  input logic [7:0]       ier_view,
  input logic             rx_irq,
  input logic             tx_irq
);

  assert_rx_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH) && tx_count <= CNT_W'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_count == CNT_W'(DEPTH) && rx_push && !rx_pop && !reg_wr_en) |=> rx_count == CNT_W'(DEPTH));

  assert_rx_flush_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_sel && reg_wr_data[1]) |=> (cfg_view[1] && rx_count == '0));

  assert_busy_empty_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_view[1] |-> rx_count == '0);

  assert_tx_flush_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_sel && reg_wr_data[2]) |=> (cfg_view[2] && tx_count == '0));

  assert_tx_trig_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_sel && !enh_en) |=> cfg_view[5:4] == $past(cfg_view[5:4]));

  assert_ier_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_sel && !enh_en) |=> ier_view[7:4] == $past(ier_view[7:4]));

  assert_rx_irq_en_R10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(ier_view[0]));

  assert_tx_irq_en_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_irq) |-> $past(ier_view[1]));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_sel  (reg_wr_sel),
  .reg_wr_data (reg_wr_data),
  .enh_en      (enh_en),
  .rx_push     (rx_push),
  .rx_pop      (rx_pop),
  .tx_count    (tx_count),
  .rx_count    (rx_count),
  .cfg_view    (cfg_view),
  .ier_view    (ier_view),
  .rx_irq      (rx_irq),
  .tx_irq      (tx_irq)
);

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 0, reg_wr_sel = 0, enh_en = 0;
  logic [7:0] reg_wr_data = 0;
  logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_push_data = 0, rx_push_data = 0;
  logic [7:0] tx_pop_data, rx_pop_data, cfg_view, ier_view;
  logic [6:0] tx_count, rx_count;
  logic       rx_irq, tx_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  uart_fifo_ctrl u_uart_fifo_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .enh_en(enh_en),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
    .tx_count(tx_count), .rx_count(rx_count), .cfg_view(cfg_view), .ier_view(ier_view),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rx_tab(input bit [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 16; 2'd2: return 56; default: return 60; endcase
  endfunction
  function automatic int tx_tab(input bit [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 16; 2'd2: return 32; default: return 56; endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit         m_en, m_rirq, m_tirq, m_room_q;
  bit [1:0]   m_rtrg, m_ttrg;
  bit [7:0]   m_ier, m_rdat, m_tdat;
  int         m_rbusy, m_tbusy;

  always @(posedge clk) begin
    int  cap, rthr, tthr, rsz, tsz;
    bit  room, nr, nt, rfl, tfl;
    if (rst) begin
      rxq.delete(); txq.delete();
      m_en = 0; m_rirq = 0; m_tirq = 0; m_room_q = 0;
      m_rtrg = 0; m_ttrg = 0; m_ier = 0; m_rdat = 0; m_tdat = 0;
      m_rbusy = 0; m_tbusy = 0;
    end else begin
      cap  = m_en ? DEPTH : 1;
      rthr = m_en ? rx_tab(m_rtrg) : 1;
      tthr = m_en ? tx_tab(m_ttrg) : 1;
      rsz  = rxq.size();
      tsz  = txq.size();
      room = (tsz + tthr) <= cap;
      nr   = m_ier[0] && (rsz >= rthr);
      nt   = m_ier[1] && room && (m_tirq || !m_room_q);
      rfl  = reg_wr_en && !reg_wr_sel && reg_wr_data[1];
      tfl  = reg_wr_en && !reg_wr_sel && reg_wr_data[2];
      if (rfl || m_rbusy > 0) rxq.delete();
      else begin
        if (rx_pop && rsz > 0) m_rdat = rxq.pop_front();
        if (rx_push && rsz < cap) rxq.push_back(rx_push_data);
      end
      if (tfl || m_tbusy > 0) txq.delete();
      else begin
        if (tx_pop && tsz > 0) m_tdat = txq.pop_front();
        if (tx_push && tsz < cap) txq.push_back(tx_push_data);
      end
      if (rfl) m_rbusy = 2; else if (m_rbusy > 0) m_rbusy--;
      if (tfl) m_tbusy = 2; else if (m_tbusy > 0) m_tbusy--;
      if (reg_wr_en && !reg_wr_sel) begin
        m_en   = reg_wr_data[0];
        m_rtrg = reg_wr_data[7:6];
        if (enh_en) m_ttrg = reg_wr_data[5:4];
      end
      if (reg_wr_en && reg_wr_sel) begin
        m_ier[3:0] = reg_wr_data[3:0];
        if (enh_en) m_ier[7:4] = reg_wr_data[7:4];
      end
      m_rirq   = nr;
      m_tirq   = nt;
      m_room_q = room;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3",  "rx_count",    int'(rx_count),    rxq.size());
      check("R3",  "tx_count",    int'(tx_count),    txq.size());
      check("R2",  "rx_pop_data", int'(rx_pop_data), int'(m_rdat));
      check("R2",  "tx_pop_data", int'(tx_pop_data), int'(m_tdat));
      check("R3",  "deep_en",     int'(cfg_view[0]), int'(m_en));
      check("R4",  "rx_busy",     int'(cfg_view[1]), int'(m_rbusy > 0));
      check("R5",  "tx_busy",     int'(cfg_view[2]), int'(m_tbusy > 0));
      check("R8",  "reserved",    int'(cfg_view[3]), 0);
      check("R7",  "tx_trig",     int'(cfg_view[5:4]), int'(m_ttrg));
      check("R6",  "rx_trig",     int'(cfg_view[7:6]), int'(m_rtrg));
      check("R9",  "ier",         int'(ier_view),    int'(m_ier));
      check("R10", "rx_irq",      int'(rx_irq),      int'(m_rirq));
      check("R11", "tx_irq",      int'(tx_irq),      int'(m_tirq));
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic wr(input bit sel, input logic [7:0] d);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op(input bit rp, input logic [7:0] rd, input bit rq, input bit tp, input logic [7:0] td, input bit tq);
    rx_push = rp; rx_push_data = rd; rx_pop = rq;
    tx_push = tp; tx_push_data = td; tx_pop = tq;
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", "cfg_view", int'(cfg_view), 0);
    check("R1", "ier_view", int'(ier_view), 0);
    check("R1", "counts",   int'(rx_count) + int'(tx_count), 0);
    check("R1", "irqs",     int'(rx_irq) + int'(tx_irq), 0);
    check("R1", "pop_data", int'(rx_pop_data) + int'(tx_pop_data), 0);

    // R3 single-byte capacity while deep mode is off
    op(1, 8'h11, 0, 0, 0, 0);
    op(1, 8'h22, 0, 0, 0, 0);
    op(1, 8'h33, 0, 0, 0, 0);
    check("R3", "single-byte capacity", int'(rx_count), 1);
    op(0, 0, 1, 0, 0, 0);
    check("R2", "single-byte data", int'(rx_pop_data), 8'h11);

    // R3 deep mode, overfill
    wr(0, 8'h01);
    for (int i = 0; i < 70; i++) op(1, 8'(i), 0, 0, 0, 0);
    check("R3", "deep capacity", int'(rx_count), 64);
    op(1, 8'hEE, 1, 0, 0, 0);
    check("R3", "push+pop at full", int'(rx_count), 63);
    op(0, 0, 1, 0, 0, 0);
    op(0, 0, 1, 0, 0, 0);
    check("R2", "order", int'(rx_pop_data), 2);

    // R6 and R10 receive trigger
    wr(1, 8'h01);
    idle(1);
    check("R10", "rx_irq at 61 vs 8", int'(rx_irq), 1);
    wr(0, 8'hC1);
    idle(1);
    check("R6", "rx_trig 60", int'(cfg_view[7:6]), 3);
    check("R10", "rx_irq at 61 vs 60", int'(rx_irq), 1);
    op(0, 0, 1, 0, 0, 0);
    op(0, 0, 1, 0, 0, 0);
    idle(1);
    check("R10", "rx_irq at 59 vs 60", int'(rx_irq), 0);

    // R7 gating of transmit trigger
    enh_en = 0;
    wr(0, 8'hF1);
    check("R7", "tx_trig held", int'(cfg_view[5:4]), 0);
    enh_en = 1;
    wr(0, 8'h21);
    check("R7", "tx_trig written", int'(cfg_view[5:4]), 2);
    // R8 reserved bit
    wr(0, 8'h29);
    check("R8", "bit3 ignored", int'(cfg_view), 8'h21);

    // R9 interrupt enable gating
    enh_en = 0;
    wr(1, 8'hF3);
    check("R9", "upper held", int'(ier_view), 8'h03);
    enh_en = 1;
    wr(1, 8'hF3);
    check("R9", "upper written", int'(ier_view), 8'hF3);
    wr(1, 8'h01);

    // R11 transmit crossing
    wr(1, 8'h03);
    idle(3);
    check("R11", "no fire on enable", int'(tx_irq), 0);
    for (int i = 0; i < 40; i++) op(0, 0, 0, 1, 8'(100 + i), 0);
    idle(2);
    check("R11", "space 24 below 32", int'(tx_irq), 0);
    for (int i = 0; i < 8; i++) op(0, 0, 0, 0, 0, 1);
    idle(2);
    check("R11", "fresh crossing", int'(tx_irq), 1);
    check("R2", "tx order", int'(tx_pop_data), 107);
    wr(1, 8'h01);
    idle(2);
    check("R11", "cleared on disable", int'(tx_irq), 0);
    wr(1, 8'h03);
    idle(3);
    check("R11", "no retrigger", int'(tx_irq), 0);

    // R4 receive flush
    wr(0, 8'h23);
    check("R4", "busy after write", int'(cfg_view[1]), 1);
    check("R4", "rx emptied", int'(rx_count), 0);
    check("R4", "tx untouched", int'(tx_count), 32);
    op(1, 8'h55, 0, 0, 0, 0);
    check("R4", "busy second cycle", int'(cfg_view[1]), 1);
    check("R4", "push dropped while busy", int'(rx_count), 0);
    op(1, 8'h56, 0, 0, 0, 0);
    check("R4", "busy released", int'(cfg_view[1]), 0);
    check("R4", "push dropped last busy", int'(rx_count), 0);
    op(1, 8'h57, 0, 0, 0, 0);
    check("R4", "push after flush", int'(rx_count), 1);

    // R5 transmit flush
    wr(0, 8'h25);
    check("R5", "tx emptied", int'(tx_count), 0);
    check("R5", "tx busy", int'(cfg_view[2]), 1);
    check("R5", "rx untouched", int'(rx_count), 1);
    idle(2);
    check("R5", "tx busy released", int'(cfg_view[2]), 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit fill;
      logic [7:0] d;
      fill = ((i / 400) % 2) == 0;
      rx_push = fill ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
      tx_push = fill ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
      rx_pop  = fill ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0);
      tx_pop  = fill ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0);
      rx_push_data = 8'($urandom);
      tx_push_data = 8'($urandom);
      reg_wr_en = ($urandom_range(0, 40) == 0);
      reg_wr_sel = 1'($urandom);
      d = 8'($urandom);
      if ($urandom_range(0, 5) != 0) d[2:1] = 2'b00;
      if ($urandom_range(0, 4) != 0) d[0] = 1'b1;
      reg_wr_data = d;
      enh_en = 1'($urandom);
      @(negedge clk);
    end
    reg_wr_en = 0; rx_push = 0; tx_push = 0; rx_pop = 0; tx_pop = 0;
    idle(3);
    finish_run();
  end

endmodule